// File: doc/BRIEF.md
# Coprocessor Debug Mode Controller

This block decides when a small load/store coprocessor stops for debugging, when it runs again, and where it runs from. It sits between an external breakpoint unit, a software-visible debug-enable bit and the core. Each cycle it drives one go signal. While go is high, the core executes and retires the instruction at its program counter. While go is low, the core holds all of its state, including the program counter. There are two ways to stop the core. A breakpoint tag on the fetched opcode stops it before that opcode runs. A forced break, or software setting the enable bit, lets the current instruction finish and then stops the core.

The block also owns the debug register access port. A selector names one debug-visible register: selects 0 to 7 are general registers 0 to 7, select 8 is the condition codes and select 9 is the program counter. Reads are captured one cycle after the read strobe. Writes are forwarded to the core as a write enable. When the device is secured, reads return zero, writes are dropped and single-step requests are ignored. Outside debug mode the block runs the core whenever a thread is active, meaning the channel ID is nonzero. With no active thread it keeps the core idle.

Top module: `cop_dbg_ctrl`

## Requirements
- R1: While running, a cycle with `brk_tag` high has `core_go` low. The next cycle has `debug_mode` high, and the program counter is unchanged.
- R2: While running, a cycle with `brk_force` high (and `brk_tag` low) keeps `core_go` high. The next cycle has `debug_mode` high and `core_go` low.
- R3: If `brk_tag` and `brk_force` are both high while running, the tag wins: `core_go` is low in that cycle and debug mode follows.
- R4: In debug mode, only `dbg_wr` with `dbg_wdata`=0 ends debug mode. Breakpoints, writing 1, and changes of the channel ID leave `debug_mode` high and `core_go` low.
- R5: A clearing write while a thread is active drops `debug_mode` in the next cycle, and `core_go` is high from that cycle.
- R6: A clearing write with channel ID zero drops `debug_mode` in the next cycle and leaves `core_go` low.
- R7: While `secured` is high, a read of any select 0 to 9 returns zero on `acc_rdata` one cycle after `acc_rd`.
- R8: While `secured` is high, `core_we` stays low, so the register addressed by the write keeps its value.
- R9: While `secured` is high, `step_req` in debug mode is ignored: `core_go` stays low.
- R10: While not secured, `step_req` in debug mode makes `core_go` high for exactly the next cycle. `debug_mode` stays high and the program counter advances by one.
- R11: While not secured, `acc_rdata` shows the core's value of the selected register one cycle after `acc_rd`, and `acc_wr` raises `core_we` in the same cycle. Selects above 9 read zero and never write.
- R12: While running, `dbg_wr` with `dbg_wdata`=1 keeps `core_go` high for that cycle and enters debug mode in the next cycle.
- R13: Out of reset, `debug_mode`, `core_go` and `acc_rdata` are low. With a nonzero channel ID the core runs one instruction per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chan_id | input | CHID_W | Active channel ID; nonzero means a thread is active |
| brk_tag | input | 1 | Fetched opcode carries a breakpoint tag |
| brk_force | input | 1 | Forced breakpoint request |
| dbg_wr | input | 1 | Write strobe for the debug-enable bit |
| dbg_wdata | input | 1 | Value written to the debug-enable bit |
| step_req | input | 1 | Single-step request |
| secured | input | 1 | Device secured flag |
| acc_sel | input | SEL_W | Register select (0-7 general, 8 condition codes, 9 program counter) |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | DATA_W | Write data |
| acc_rdata | output | DATA_W | Captured read data |
| core_rdata | input | DATA_W | Core's value of the selected register |
| core_sel | output | SEL_W | Register select to the core |
| core_we | output | 1 | Register write enable to the core |
| core_wdata | output | DATA_W | Register write data to the core |
| core_go | output | 1 | Core may execute and retire this cycle |
| debug_mode | output | 1 | Core is in debug mode |

## Verification
The bench goes after the same-cycle tie between a tag and a forced break. A design that let the force win there would retire the tagged opcode and leave the program counter one past it. It drives breakpoints and enable writes of 1 while the core is already stopped, which would release or re-trigger a controller that accepts any event as an exit. It steps once with security off and once with it on: a wrong design would either run on after one instruction or step while secured. It leaves debug mode with the channel ID cleared, where a wrong design would start fetching with no thread, and it checks that secured reads are zero on every select and that a secured write leaves the register unchanged.

// File: rtl/cop_dbg_pkg.sv
package cop_dbg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HALT = 2'd2,
      ST_STEP = 2'd3
   } dbg_state_t;
endpackage

// File: rtl/cop_dbg_fsm.sv
module cop_dbg_fsm
   import cop_dbg_pkg::*;
#(
   parameter int CHID_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHID_W-1:0] chan_id,
   input  logic              brk_tag,
   input  logic              brk_force,
   input  logic              dbg_wr,
   input  logic              dbg_wdata,
   input  logic              step_req,
   input  logic              secured,
   output logic              core_go,
   output logic              debug_mode
);
   generate
      if (CHID_W < 1) begin : g_bad_chid
         $error("CHID_W must be at least 1");
      end
   endgenerate

   dbg_state_t state_q, state_d;
   logic thread, clr_req, set_req, step_ok;

   assign thread  = |chan_id;
   assign clr_req = dbg_wr & ~dbg_wdata;
   assign set_req = dbg_wr & dbg_wdata;
   assign step_ok = step_req & ~secured & thread;

   always_comb begin
      state_d = state_q;
      core_go = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (set_req || brk_force) state_d = ST_HALT;
            else if (thread)          state_d = ST_RUN;
         end
         ST_RUN: begin
            core_go = thread & ~brk_tag;
            if (thread && brk_tag)          state_d = ST_HALT;
            else if (brk_force || set_req)  state_d = ST_HALT;
            else if (!thread)               state_d = ST_IDLE;
         end
         ST_HALT: begin
            if (clr_req)      state_d = thread ? ST_RUN : ST_IDLE;
            else if (step_ok) state_d = ST_STEP;
         end
         ST_STEP: begin
            core_go = thread;
            if (clr_req) state_d = thread ? ST_RUN : ST_IDLE;
            else         state_d = ST_HALT;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign debug_mode = (state_q == ST_HALT) || (state_q == ST_STEP);

   assert_tag_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && brk_tag) |-> !core_go);
   assert_tag_halts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && brk_tag && thread) |=> debug_mode);
   assert_force_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && brk_force) |=> (debug_mode && !core_go));
   assert_stay_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (debug_mode && !clr_req) |=> debug_mode);
   assert_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (debug_mode && clr_req) |=> !debug_mode);
   assert_secure_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT && secured) |=> (state_q != ST_STEP));
   assert_single_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STEP) |=> (state_q != ST_STEP));
   assert_halt_no_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HALT) |-> !core_go);
endmodule

// File: rtl/cop_dbg_access.sv
module cop_dbg_access #(
   parameter int DATA_W    = 16,
   parameter int SEL_W     = 4,
   parameter int NUM_GPR   = 8,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              secured,
   input  logic [SEL_W-1:0]  acc_sel,
   input  logic              acc_rd,
   input  logic              acc_wr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic [DATA_W-1:0] core_rdata,
   output logic [SEL_W-1:0]  core_sel,
   output logic              core_we,
   output logic [DATA_W-1:0] core_wdata
);
   localparam int NUM_VIS = NUM_GPR + 2;

   generate
      if (SEL_W < $clog2(NUM_VIS)) begin : g_bad_sel
         $error("SEL_W too narrow for the visible register count");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic              sel_ok;
   logic [DATA_W-1:0] rd_value;

   assign sel_ok     = (int'(acc_sel) < NUM_VIS);
   assign core_sel   = acc_sel;
   assign core_wdata = acc_wdata;
   assign core_we    = acc_wr & ~secured & sel_ok;
   assign rd_value   = (secured || !sel_ok) ? '0 : core_rdata;

   generate
      if (REG_RDATA) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      rdata_q <= '0;
            else if (acc_rd) rdata_q <= rd_value;
         end
         assign acc_rdata = rdata_q;

         assert_secure_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_rd && secured) |=> (acc_rdata == '0));
         assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_rd |=> $stable(acc_rdata));
      end else begin : g_rd_comb
         assign acc_rdata = rd_value;

         assert_secure_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            secured |-> (acc_rdata == '0));
      end
   endgenerate

   assert_secure_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      secured |-> !core_we);
   assert_bad_sel_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(acc_sel) >= NUM_VIS) |-> !core_we);
endmodule

// File: rtl/cop_dbg_ctrl.sv
module cop_dbg_ctrl #(
   parameter int DATA_W    = 16,
   parameter int SEL_W     = 4,
   parameter int NUM_GPR   = 8,
   parameter int CHID_W    = 7,
   parameter bit REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHID_W-1:0] chan_id,
   input  logic              brk_tag,
   input  logic              brk_force,
   input  logic              dbg_wr,
   input  logic              dbg_wdata,
   input  logic              step_req,
   input  logic              secured,
   input  logic [SEL_W-1:0]  acc_sel,
   input  logic              acc_rd,
   input  logic              acc_wr,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic [DATA_W-1:0] core_rdata,
   output logic [SEL_W-1:0]  core_sel,
   output logic              core_we,
   output logic [DATA_W-1:0] core_wdata,
   output logic              core_go,
   output logic              debug_mode
);
   cop_dbg_fsm #(.CHID_W(CHID_W)) i_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_id    (chan_id),
      .brk_tag    (brk_tag),
      .brk_force  (brk_force),
      .dbg_wr     (dbg_wr),
      .dbg_wdata  (dbg_wdata),
      .step_req   (step_req),
      .secured    (secured),
      .core_go    (core_go),
      .debug_mode (debug_mode)
   );

   cop_dbg_access #(
      .DATA_W    (DATA_W),
      .SEL_W     (SEL_W),
      .NUM_GPR   (NUM_GPR),
      .REG_RDATA (REG_RDATA)
   ) i_access (
      .clk        (clk),
      .rst_n      (rst_n),
      .secured    (secured),
      .acc_sel    (acc_sel),
      .acc_rd     (acc_rd),
      .acc_wr     (acc_wr),
      .acc_wdata  (acc_wdata),
      .acc_rdata  (acc_rdata),
      .core_rdata (core_rdata),
      .core_sel   (core_sel),
      .core_we    (core_we),
      .core_wdata (core_wdata)
   );

   assert_reset_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!debug_mode && chan_id == '0) |-> !core_go);
endmodule

// File: tb/test_cop_dbg_ctrl.sv
module test_cop_dbg_ctrl;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  chan_id = '0;
   logic        brk_tag = 0, brk_force = 0, dbg_wr = 0, dbg_wdata = 0;
   logic        step_req = 0, secured = 0, acc_rd = 0, acc_wr = 0;
   logic [3:0]  acc_sel = '0;
   logic [15:0] acc_wdata = '0;
   logic [15:0] acc_rdata, core_rdata, core_wdata;
   logic [3:0]  core_sel;
   logic        core_we, core_go, debug_mode;

   int n_chk = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   cop_dbg_ctrl i_cop_dbg_ctrl (
      .clk(clk), .rst_n(rst_n), .chan_id(chan_id), .brk_tag(brk_tag),
      .brk_force(brk_force), .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata),
      .step_req(step_req), .secured(secured), .acc_sel(acc_sel),
      .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .core_rdata(core_rdata), .core_sel(core_sel),
      .core_we(core_we), .core_wdata(core_wdata), .core_go(core_go),
      .debug_mode(debug_mode)
   );

   // stub core: program counter and ten visible registers
   logic [15:0] pc;
   logic [15:0] sregs [10];
   always @(posedge clk) begin
      if (!rst_n) begin
         pc <= 16'h0100;
         for (int i = 0; i < 10; i++) sregs[i] <= 16'h1000 + 16'(i) * 16'h0111;
      end else begin
         if (core_go) pc <= pc + 16'd1;
         if (core_we && core_sel < 4'd10) sregs[core_sel] <= core_wdata;
      end
   end
   assign core_rdata = (core_sel < 4'd10) ? sregs[core_sel] : 16'hDEAD;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic leave_debug();
      dbg_wr = 1; dbg_wdata = 0;
      tick();
      dbg_wr = 0;
      #1;
   endtask

   task automatic read_reg(input logic [3:0] s, output logic [15:0] v);
      acc_sel = s; acc_rd = 1;
      tick();
      acc_rd = 0;
      #1 v = acc_rdata;
   endtask

   task automatic t_reset();
      #1;
      chk("R13 reset debug_mode", debug_mode, 0);
      chk("R13 reset core_go", core_go, 0);
      chk("R13 reset rdata", acc_rdata, 0);
   endtask

   task automatic t_run();
      logic [15:0] p0;
      chan_id = 7'd3;
      tick();
      #1 chk("R13 run go", core_go, 1);
      p0 = pc;
      tick(); tick(); tick();
      chk("R13 pc advance", pc, p0 + 16'd3);
   endtask

   task automatic t_tag();
      logic [15:0] p0;
      p0 = pc;
      brk_tag = 1;
      #1 chk("R1 go blocked", core_go, 0);
      tick();
      brk_tag = 0;
      #1;
      chk("R1 debug entered", debug_mode, 1);
      chk("R1 pc at tagged op", pc, p0);
   endtask

   task automatic t_stay();
      logic [15:0] p0;
      p0 = pc;
      dbg_wr = 1; dbg_wdata = 1; brk_force = 1; brk_tag = 1;
      tick();
      chan_id = 7'd0;
      tick();
      dbg_wr = 0; brk_force = 0; brk_tag = 0; chan_id = 7'd3;
      #1;
      chk("R4 still debug", debug_mode, 1);
      chk("R4 go low", core_go, 0);
      chk("R4 pc held", pc, p0);
   endtask

   task automatic t_step();
      logic [15:0] p0;
      p0 = pc;
      step_req = 1;
      tick();
      step_req = 0;
      #1;
      chk("R10 step go", core_go, 1);
      chk("R10 step debug", debug_mode, 1);
      tick();
      #1;
      chk("R10 one only", core_go, 0);
      chk("R10 pc next", pc, p0 + 16'd1);
      chk("R10 back to debug", debug_mode, 1);
   endtask

   task automatic t_exit();
      leave_debug();
      chk("R5 debug off", debug_mode, 0);
      chk("R5 resume go", core_go, 1);
   endtask

   task automatic t_force();
      logic [15:0] p0;
      p0 = pc;
      brk_force = 1;
      #1 chk("R2 current completes", core_go, 1);
      tick();
      brk_force = 0;
      #1;
      chk("R2 debug entered", debug_mode, 1);
      chk("R2 go low", core_go, 0);
      chk("R2 pc after op", pc, p0 + 16'd1);
   endtask

   task automatic t_tie();
      logic [15:0] p0;
      p0 = pc;
      brk_tag = 1; brk_force = 1;
      #1 chk("R3 tag wins go", core_go, 0);
      tick();
      brk_tag = 0; brk_force = 0;
      #1;
      chk("R3 debug entered", debug_mode, 1);
      chk("R3 pc at tagged op", pc, p0);
   endtask

   task automatic t_sw_enter();
      dbg_wr = 1; dbg_wdata = 1;
      #1 chk("R12 go this cycle", core_go, 1);
      tick();
      dbg_wr = 0;
      #1;
      chk("R12 debug entered", debug_mode, 1);
      chk("R12 go low", core_go, 0);
   endtask

   task automatic t_secure();
      logic [15:0] p0, v;
      secured = 1;
      p0 = pc;
      step_req = 1;
      tick();
      step_req = 0;
      #1 chk("R9 no step", core_go, 0);
      tick();
      chk("R9 pc held", pc, p0);
      for (int s = 0; s < 10; s++) begin
         read_reg(4'(s), v);
         chk("R7 secured read", v, 0);
      end
      acc_sel = 4'd2; acc_wdata = 16'hBEEF; acc_wr = 1;
      #1 chk("R8 no write enable", core_we, 0);
      tick();
      acc_wr = 0; secured = 0;
      read_reg(4'd2, v);
      chk("R8 register kept", v, 16'h1222);
   endtask

   task automatic t_access();
      logic [15:0] v;
      acc_sel = 4'd8; acc_wdata = 16'h5A5A; acc_wr = 1;
      #1 chk("R11 write enable", core_we, 1);
      tick();
      acc_wr = 0;
      read_reg(4'd8, v);
      chk("R11 read back", v, 16'h5A5A);
      read_reg(4'd9, v);
      chk("R11 read pc slot", v, 16'h1999);
      acc_sel = 4'd12; acc_wr = 1;
      #1 chk("R11 bad select no write", core_we, 0);
      tick();
      acc_wr = 0;
      read_reg(4'd12, v);
      chk("R11 bad select reads zero", v, 0);
   endtask

   task automatic t_idle_exit();
      logic [15:0] p0;
      chan_id = 7'd0;
      leave_debug();
      chk("R6 debug off", debug_mode, 0);
      chk("R6 no go", core_go, 0);
      p0 = pc;
      tick(); tick();
      #1;
      chk("R6 pc held", pc, p0);
      chk("R6 still idle", core_go, 0);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      tick(); tick(); tick();
      rst_n = 1;
      t_reset();
      t_run();
      t_tag();
      t_stay();
      t_step();
      t_exit();
      t_force();
      leave_debug();
      t_tie();
      leave_debug();
      t_sw_enter();
      t_secure();
      t_access();
      t_idle_exit();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule